// File: doc/BRIEF.md
# DRAM Low-Power State Sequencer

This block decides when a DRAM controller moves the memory into and out of its low-power states. It watches how long the controller has been idle, the control bits that software writes, the memory type and whether initialisation is still running. From these it steps through six states: normal, power-down, self refresh, self-refresh power-down, deep power-down and maximum power saving.

Each state change is issued as a request. An entry request is a one-cycle pulse. An exit request is held until the command side returns an exit-done handshake. The block also drives the DRAM clock-stop output. After deep power-down ends it raises a re-initialisation request.

All control bits may change at any cycle, and the sequencer reacts to the new values on the next clock edge. The two idle timeouts are given in units of 32 clocks. A timeout of zero turns that timer off.

Top module: `dram_lp_sequencer`

## Requirements
- R1: With `cfg_pd_en` set and `pd_idle_x32` = N > 0, the state goes from 0 to 1 on the clock edge that follows N*32 consecutive idle edges. An idle edge is one where the state is normal, no exit is pending, `txn_empty` is 1 and `txn_new` is 0.
- R2: With `cfg_sr_auto_en` set and `sr_idle_x32` = M > 0, the state goes from 0 to 2 on the edge that follows M*32 consecutive idle edges. Any non-idle edge restarts both counts from zero.
- R3: A timeout field of 0 disables its timer, so no timer entry happens however long the block stays idle.
- R4: Software self refresh:
  - From normal, `cfg_sw_sr`=1 moves the state to 2 on the next edge.
  - Clearing the bit starts the exit.
  - The bit is ignored while `init_busy` is 1, and while the state is 4 or 5.
  - In state 1, setting the bit starts an exit from power-down.
- R5: LPDDR4 (`mem_kind`=3):
  - Self refresh (2) moves to self-refresh power-down (3) on the next edge unless `cfg_sr_hold` is 1.
  - A wake in state 3 returns the state to 2.
  - While the hold bit is set and no exit is pending, state 2 is kept.
- R6: Deep power-down:
  - It is entered (state 4) only when `mem_kind`=2 (LPDDR3), `cfg_dpd_en`=1 and `txn_empty`=1.
  - It is kept while the enable stays 1.
  - Clearing the enable starts an exit. On exit-done, `reinit_req` is high for exactly the first normal cycle.
- R7: Maximum power saving (state 5) is entered only when `mem_kind`=1 (DDR4), `cfg_mps_en`=1 and `txn_empty`=1. Clearing the enable starts the exit.
- R8: `dram_clk_off` is 0 when `cfg_clkstop_en` is 0 and while an exit is pending. Otherwise it is 1 only in these states:
  - DDR3 (`mem_kind`=0): state 2.
  - DDR4: states 2 and 5.
  - LPDDR3: states 1, 2 and 4, and state 0 with `txn_empty`=1.
  - LPDDR4: states 1 and 3, and state 0 with `txn_empty`=1.
- R9: A `txn_new` pulse in state 1, or in a self refresh that a timer started, raises the exit request on the next edge. The state holds until `exit_done` is sampled high, and then returns to 0 on that edge.
- R10: When several entries are eligible on the same edge, the order of priority is software self refresh, deep power-down, maximum power saving, timer self refresh, power-down.
- R11: `enter_req` bit k-1 pulses for one cycle in the first cycle of state k. `exit_req` bit k-1 is held high while an exit from state k is pending. At most one bit of each is set.
- R12: `lp_state` encodes 0 normal, 1 power-down, 2 self refresh, 3 self-refresh power-down, 4 deep power-down, 5 maximum power saving. After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_pd_en | input | 1 | Enable power-down after the idle timeout |
| cfg_sr_auto_en | input | 1 | Enable self refresh after the idle timeout |
| cfg_sw_sr | input | 1 | Software self-refresh request (1 enter, 0 leave) |
| cfg_sr_hold | input | 1 | Keep the self-refresh state (LPDDR4) |
| cfg_dpd_en | input | 1 | Enable deep power-down |
| cfg_mps_en | input | 1 | Enable maximum power saving |
| cfg_clkstop_en | input | 1 | Allow the DRAM clock to be stopped |
| pd_idle_x32 | input | TMO_W | Power-down idle timeout in units of 32 clocks |
| sr_idle_x32 | input | TMO_W | Self-refresh idle timeout in units of 32 clocks |
| mem_kind | input | 2 | Memory type: 0 DDR3, 1 DDR4, 2 LPDDR3, 3 LPDDR4 |
| init_busy | input | 1 | Memory initialisation in progress |
| txn_empty | input | 1 | Transaction store is empty |
| txn_new | input | 1 | A new transaction arrives this cycle |
| exit_done | input | 1 | Command side has finished the requested exit |
| lp_state | output | 3 | Encoded current state |
| enter_req | output | 5 | One-cycle entry pulse per state |
| exit_req | output | 5 | Held exit request per state |
| reinit_req | output | 1 | Re-initialise the memory after deep power-down |
| dram_clk_off | output | 1 | Stop the DRAM clock |

## Verification
The hardest path to reach is the LPDDR4 path that leaves self-refresh power-down. It goes back through self refresh with the hold bit set, has its wake stored, and leaves only once the hold is released. The stimulus reaches it in steps:
- Enter self refresh by software with the hold set, then release the hold to reach power-down.
- Set the hold again and clear the software bit in the same cycle.
- Release the hold after a few cycles.

Reaching the re-initialisation pulse is also indirect. The store is left empty with deep power-down enabled, so the state falls into deep power-down straight after a software self-refresh exit. The exit handshake is then completed.

A reference model in the bench predicts state, entry/exit requests, re-initialisation and clock stop for every cycle.

// File: rtl/lpseq_pkg.sv
`timescale 1ns/1ps
package lpseq_pkg;
  localparam logic [2:0] ST_NORM = 3'd0;
  localparam logic [2:0] ST_PD   = 3'd1;
  localparam logic [2:0] ST_SR   = 3'd2;
  localparam logic [2:0] ST_SRPD = 3'd3;
  localparam logic [2:0] ST_DPD  = 3'd4;
  localparam logic [2:0] ST_MPS  = 3'd5;

  localparam logic [1:0] MEM_DDR3 = 2'd0;
  localparam logic [1:0] MEM_DDR4 = 2'd1;
  localparam logic [1:0] MEM_LP3  = 2'd2;
  localparam logic [1:0] MEM_LP4  = 2'd3;

  // request vector bit for a state code; normal has none
  function automatic logic [4:0] st_onehot(input logic [2:0] st);
    logic [4:0] r;
    case (st)
      ST_PD:   r = 5'b00001;
      ST_SR:   r = 5'b00010;
      ST_SRPD: r = 5'b00100;
      ST_DPD:  r = 5'b01000;
      ST_MPS:  r = 5'b10000;
      default: r = 5'b00000;
    endcase
    return r;
  endfunction

  // may the DRAM clock be stopped in this state for this memory type
  function automatic logic clk_allowed(input logic [1:0] kind,
                                       input logic [2:0] st,
                                       input logic       idle);
    logic ok;
    case (kind)
      MEM_DDR3: ok = (st == ST_SR);
      MEM_DDR4: ok = (st == ST_SR) || (st == ST_MPS);
      MEM_LP3:  ok = (st == ST_SR) || (st == ST_PD) || (st == ST_DPD) ||
                     ((st == ST_NORM) && idle);
      default:  ok = (st == ST_SRPD) || (st == ST_PD) ||
                     ((st == ST_NORM) && idle);
    endcase
    return ok;
  endfunction
endpackage

// File: rtl/lpseq_idle_timer.sv
`timescale 1ns/1ps
module lpseq_idle_timer #(
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idle,
  input  logic [TMO_W-1:0] tmo,
  output logic             expired
);
  localparam int CNT_W = TMO_W + 5;

  // timeout field is in units of 32 clocks
  function automatic logic [CNT_W-1:0] idle_limit(input logic [TMO_W-1:0] t);
    return {t, 5'b00000};
  endfunction

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!idle)          cnt_q <= '0;
    else if (cnt_q != '1)    cnt_q <= cnt_q + 1'b1;
  end

  assign expired = (tmo != '0) && (cnt_q >= idle_limit(tmo));
endmodule

// File: rtl/lpseq_fsm.sv
`timescale 1ns/1ps
module lpseq_fsm
  import lpseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_pd_en,
  input  logic       cfg_sr_auto_en,
  input  logic       cfg_sw_sr,
  input  logic       cfg_sr_hold,
  input  logic       cfg_dpd_en,
  input  logic       cfg_mps_en,
  input  logic [1:0] mem_kind,
  input  logic       init_busy,
  input  logic       txn_empty,
  input  logic       txn_new,
  input  logic       exit_done,
  input  logic       pd_expired,
  input  logic       sr_expired,
  output logic [2:0] state,
  output logic [4:0] enter_req,
  output logic [4:0] exit_req,
  output logic       reinit_req,
  output logic       in_norm,
  output logic       exiting,
  output logic       entry_fire
);
  logic [2:0] st_q, st_d;
  logic       ex_q, ex_d;
  logic       lv_q, lv_d;     // wake seen on the way out of self refresh
  logic       src_q, src_d;   // 1: self refresh entered by software
  logic [4:0] ent_q, ent_d;
  logic       rei_q, rei_d;
  logic       pin_sr, sr_wake, sr_leave;

  assign in_norm  = (st_q == ST_NORM) && !ex_q;
  assign pin_sr   = cfg_sr_hold && (mem_kind == MEM_LP4);
  assign sr_wake  = src_q ? !cfg_sw_sr : txn_new;
  assign sr_leave = lv_q || sr_wake;

  always_comb begin
    st_d  = st_q;
    ex_d  = ex_q;
    lv_d  = lv_q;
    src_d = src_q;
    rei_d = 1'b0;
    if (ex_q) begin
      if (exit_done) begin
        st_d  = ST_NORM;
        ex_d  = 1'b0;
        lv_d  = 1'b0;
        rei_d = (st_q == ST_DPD);
      end
    end else begin
      case (st_q)
        ST_NORM: if (!init_busy) begin
          if (cfg_sw_sr) begin
            st_d = ST_SR; src_d = 1'b1;
          end else if (cfg_dpd_en && txn_empty && mem_kind == MEM_LP3) begin
            st_d = ST_DPD;
          end else if (cfg_mps_en && txn_empty && mem_kind == MEM_DDR4) begin
            st_d = ST_MPS;
          end else if (cfg_sr_auto_en && sr_expired) begin
            st_d = ST_SR; src_d = 1'b0;
          end else if (cfg_pd_en && pd_expired) begin
            st_d = ST_PD;
          end
        end
        ST_PD:   if (txn_new || cfg_sw_sr) ex_d = 1'b1;
        ST_SR: begin
          if (pin_sr)                      lv_d = sr_leave;
          else if (sr_leave)               ex_d = 1'b1;
          else if (mem_kind == MEM_LP4)    st_d = ST_SRPD;
        end
        ST_SRPD: if (sr_wake) begin
          st_d = ST_SR; lv_d = 1'b1;
        end
        ST_DPD:  if (!cfg_dpd_en) ex_d = 1'b1;
        ST_MPS:  if (!cfg_mps_en) ex_d = 1'b1;
        default: st_d = ST_NORM;
      endcase
    end
    ent_d = (st_d != st_q) ? st_onehot(st_d) : 5'b00000;
  end

  assign entry_fire = in_norm && (st_d != ST_NORM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_NORM;
      ex_q  <= 1'b0;
      lv_q  <= 1'b0;
      src_q <= 1'b0;
      ent_q <= '0;
      rei_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      ex_q  <= ex_d;
      lv_q  <= lv_d;
      src_q <= src_d;
      ent_q <= ent_d;
      rei_q <= rei_d;
    end
  end

  assign state      = st_q;
  assign exiting    = ex_q;
  assign enter_req  = ent_q;
  assign exit_req   = ex_q ? st_onehot(st_q) : 5'b00000;
  assign reinit_req = rei_q;
endmodule

// File: rtl/dram_lp_sequencer.sv
`timescale 1ns/1ps
module dram_lp_sequencer
  import lpseq_pkg::*;
#(
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_pd_en,
  input  logic             cfg_sr_auto_en,
  input  logic             cfg_sw_sr,
  input  logic             cfg_sr_hold,
  input  logic             cfg_dpd_en,
  input  logic             cfg_mps_en,
  input  logic             cfg_clkstop_en,
  input  logic [TMO_W-1:0] pd_idle_x32,
  input  logic [TMO_W-1:0] sr_idle_x32,
  input  logic [1:0]       mem_kind,
  input  logic             init_busy,
  input  logic             txn_empty,
  input  logic             txn_new,
  input  logic             exit_done,
  output logic [2:0]       lp_state,
  output logic [4:0]       enter_req,
  output logic [4:0]       exit_req,
  output logic             reinit_req,
  output logic             dram_clk_off
);
  localparam int NTMR = 2;   // 0: power-down, 1: self refresh

  logic             norm_idle;
  logic             fsm_exiting;
  logic             entry_fire;
  logic             timer_idle;
  logic [TMO_W-1:0] tmo_v [NTMR];
  logic [NTMR-1:0]  tmr_exp;

  assign timer_idle = norm_idle && txn_empty && !txn_new;
  assign tmo_v[0]   = pd_idle_x32;
  assign tmo_v[1]   = sr_idle_x32;

  for (genvar gi = 0; gi < NTMR; gi++) begin : g_tmr
    lpseq_idle_timer #(.TMO_W(TMO_W)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .idle    (timer_idle),
      .tmo     (tmo_v[gi]),
      .expired (tmr_exp[gi])
    );
  end

  lpseq_fsm u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_pd_en      (cfg_pd_en),
    .cfg_sr_auto_en (cfg_sr_auto_en),
    .cfg_sw_sr      (cfg_sw_sr),
    .cfg_sr_hold    (cfg_sr_hold),
    .cfg_dpd_en     (cfg_dpd_en),
    .cfg_mps_en     (cfg_mps_en),
    .mem_kind       (mem_kind),
    .init_busy      (init_busy),
    .txn_empty      (txn_empty),
    .txn_new        (txn_new),
    .exit_done      (exit_done),
    .pd_expired     (tmr_exp[0]),
    .sr_expired     (tmr_exp[1]),
    .state          (lp_state),
    .enter_req      (enter_req),
    .exit_req       (exit_req),
    .reinit_req     (reinit_req),
    .in_norm        (norm_idle),
    .exiting        (fsm_exiting),
    .entry_fire     (entry_fire)
  );

  assign dram_clk_off = cfg_clkstop_en && !fsm_exiting &&
                        clk_allowed(mem_kind, lp_state, txn_empty);
endmodule

// File: rtl/dram_lp_sequencer_chk.sv
`timescale 1ns/1ps
module dram_lp_sequencer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_clkstop_en,
  input logic       cfg_dpd_en,
  input logic       cfg_sr_hold,
  input logic [1:0] mem_kind,
  input logic [2:0] lp_state,
  input logic [4:0] enter_req,
  input logic [4:0] exit_req,
  input logic       reinit_req,
  input logic       dram_clk_off,
  input logic       entry_fire
);
  a_r11_enter_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(enter_req));
  a_r11_exit_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(exit_req));
  a_r8_clk_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_clkstop_en |-> !dram_clk_off);
  a_r8_clk_on_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (exit_req != 5'b0) |-> !dram_clk_off);
  a_r6_reinit_after_dpd: assert property (@(posedge clk) disable iff (!rst_n)
    reinit_req |-> ($past(lp_state) == 3'd4) && (lp_state == 3'd0));
  a_r6_dpd_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_state == 3'd4 && cfg_dpd_en && exit_req == 5'b0) |=> (lp_state == 3'd4));
  a_r5_hold_pins: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_state == 3'd2 && cfg_sr_hold && mem_kind == 2'd3 && exit_req == 5'b0)
      |=> (lp_state == 3'd2));
  a_r12_code_range: assert property (@(posedge clk) disable iff (!rst_n)
    lp_state <= 3'd5);
  a_r10_entry_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    entry_fire |=> (enter_req != 5'b0) && (lp_state != 3'd0));
endmodule

bind dram_lp_sequencer dram_lp_sequencer_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cfg_clkstop_en (cfg_clkstop_en),
  .cfg_dpd_en     (cfg_dpd_en),
  .cfg_sr_hold    (cfg_sr_hold),
  .mem_kind       (mem_kind),
  .lp_state       (lp_state),
  .enter_req      (enter_req),
  .exit_req       (exit_req),
  .reinit_req     (reinit_req),
  .dram_clk_off   (dram_clk_off),
  .entry_fire     (entry_fire)
);

// File: tb/sim_dram_lp_sequencer.sv
`timescale 1ns/1ps
module sim_dram_lp_sequencer;
  localparam int TW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pd_en = 0, sra_en = 0, sw = 0, hold = 0, dpd_en = 0, mps_en = 0, ck_en = 0;
  logic [TW-1:0] pd_tmo = '0, sr_tmo = '0;
  logic [1:0] kind = 2'd0;
  logic init_busy = 0, txn_empty = 0, txn_new = 0, exit_done = 0;
  logic [2:0] lp_state;
  logic [4:0] enter_req, exit_req;
  logic reinit_req, dram_clk_off;

  always #5 clk = ~clk;

  dram_lp_sequencer #(.TMO_W(TW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_pd_en(pd_en), .cfg_sr_auto_en(sra_en), .cfg_sw_sr(sw),
    .cfg_sr_hold(hold), .cfg_dpd_en(dpd_en), .cfg_mps_en(mps_en),
    .cfg_clkstop_en(ck_en), .pd_idle_x32(pd_tmo), .sr_idle_x32(sr_tmo),
    .mem_kind(kind), .init_busy(init_busy), .txn_empty(txn_empty),
    .txn_new(txn_new), .exit_done(exit_done),
    .lp_state(lp_state), .enter_req(enter_req), .exit_req(exit_req),
    .reinit_req(reinit_req), .dram_clk_off(dram_clk_off)
  );

  int n_run = 0;
  int n_fail = 0;

  task automatic chk(input string tag, input int act, input int exp_v);
    n_run++;
    if (act != exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
    end
  endtask

  // ---------------- reference model and scoreboard ----------------
  typedef struct packed {
    logic [2:0] st;
    logic [4:0] en;
    logic [4:0] ex;
    logic       rei;
    logic       ck;
  } exp_t;
  exp_t sb_q[$];

  int m_st = 0, m_cpd = 0, m_csr = 0;
  bit m_ex = 0, m_lv = 0, m_sw = 0, m_rei = 0;
  bit [4:0] m_en = 0;

  function automatic bit ref_clk(int k, int s, bit idle);
    if (k == 0) return s == 2;
    if (k == 1) return s == 2 || s == 5;
    if (k == 2) return s == 1 || s == 2 || s == 4 || (s == 0 && idle);
    return s == 1 || s == 3 || (s == 0 && idle);
  endfunction

  function automatic bit [4:0] bitof(int s);
    return (s == 0) ? 5'd0 : 5'd1 << (s - 1);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_ex = 0; m_lv = 0; m_sw = 0; m_rei = 0; m_en = 0;
      m_cpd = 0; m_csr = 0;
    end else begin
      bit pd_x, sr_x, nrm, idl, wake, nex, nlv, nsw, nrei;
      int ns;
      exp_t e;
      pd_x = (pd_tmo != 0) && (m_cpd >= 32 * int'(pd_tmo));
      sr_x = (sr_tmo != 0) && (m_csr >= 32 * int'(sr_tmo));
      nrm  = (m_st == 0) && !m_ex;
      idl  = nrm && txn_empty && !txn_new;
      ns = m_st; nex = m_ex; nlv = m_lv; nsw = m_sw; nrei = 0;
      wake = m_sw ? !sw : txn_new;
      if (m_ex) begin
        if (exit_done) begin ns = 0; nex = 0; nlv = 0; nrei = (m_st == 4); end
      end else if (m_st == 0) begin
        if (!init_busy) begin
          if (sw) begin ns = 2; nsw = 1; end
          else if (dpd_en && txn_empty && kind == 2) ns = 4;
          else if (mps_en && txn_empty && kind == 1) ns = 5;
          else if (sra_en && sr_x) begin ns = 2; nsw = 0; end
          else if (pd_en && pd_x) ns = 1;
        end
      end else if (m_st == 1) begin
        if (txn_new || sw) nex = 1;
      end else if (m_st == 2) begin
        if (hold && kind == 3) nlv = m_lv || wake;
        else if (m_lv || wake) nex = 1;
        else if (kind == 3) ns = 3;
      end else if (m_st == 3) begin
        if (wake) begin ns = 2; nlv = 1; end
      end else if (m_st == 4) begin
        if (!dpd_en) nex = 1;
      end else if (m_st == 5) begin
        if (!mps_en) nex = 1;
      end
      m_en  = (ns != m_st) ? bitof(ns) : 5'd0;
      m_cpd = idl ? m_cpd + 1 : 0;
      m_csr = idl ? m_csr + 1 : 0;
      m_st = ns; m_ex = nex; m_lv = nlv; m_sw = nsw; m_rei = nrei;
      e.st  = 3'(m_st);
      e.en  = m_en;
      e.ex  = m_ex ? bitof(m_st) : 5'd0;
      e.rei = m_rei;
      e.ck  = ck_en && !m_ex && ref_clk(int'(kind), m_st, txn_empty);
      sb_q.push_back(e);
    end
  end

  always @(posedge clk) begin
    #1;
    if (sb_q.size() != 0) begin
      exp_t e;
      e = sb_q.pop_front();
      chk("R12 model state", int'(lp_state), int'(e.st));
      chk("R11 model enter_req", int'(enter_req), int'(e.en));
      chk("R11 model exit_req", int'(exit_req), int'(e.ex));
      chk("R6 model reinit_req", int'(reinit_req), int'(e.rei));
      chk("R8 model dram_clk_off", int'(dram_clk_off), int'(e.ck));
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_exit();
    @(negedge clk); exit_done = 1;
    tick(1);
    chk("R9 back to normal", int'(lp_state), 0);
    @(negedge clk); exit_done = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    tick(1);
    chk("R12 reset state", int'(lp_state), 0);
    chk("R12 reset enter", int'(enter_req), 0);
    chk("R12 reset exit", int'(exit_req), 0);
    chk("R12 reset clk_off", int'(dram_clk_off), 0);

    // R1: power-down after 1*32 idle edges
    @(negedge clk); pd_en = 1; pd_tmo = 1; txn_empty = 1;
    tick(32);
    chk("R1 not yet in power-down", int'(lp_state), 0);
    tick(1);
    chk("R1 power-down entered", int'(lp_state), 1);
    chk("R11 enter pulse pd", int'(enter_req), 1);
    tick(1);
    chk("R11 enter pulse one cycle", int'(enter_req), 0);
    // R9: arrival wakes power-down, waits for done
    @(negedge clk); txn_new = 1; txn_empty = 0;
    tick(1);
    chk("R9 exit_req pd", int'(exit_req), 1);
    @(negedge clk); txn_new = 0;
    tick(3);
    chk("R9 held until done", int'(lp_state), 1);
    finish_exit();

    // R3: zero timeout disables the timer
    @(negedge clk); pd_tmo = 0; txn_empty = 1;
    tick(100);
    chk("R3 zero timeout no entry", int'(lp_state), 0);
    @(negedge clk); kind = 2; ck_en = 1;
    tick(1);
    chk("R8 LPDDR3 idle clock stop", int'(dram_clk_off), 1);
    @(negedge clk); txn_empty = 0;
    tick(1);
    chk("R8 LPDDR3 busy clock runs", int'(dram_clk_off), 0);

    // R2/R10: timer self refresh (64) beats power-down (96)
    @(negedge clk); kind = 0; pd_tmo = 3; sra_en = 1; sr_tmo = 2; txn_empty = 1;
    tick(64);
    chk("R2 not yet in self refresh", int'(lp_state), 0);
    chk("R8 DDR3 normal clock runs", int'(dram_clk_off), 0);
    tick(1);
    chk("R2 self refresh entered", int'(lp_state), 2);
    chk("R8 DDR3 self refresh clock stop", int'(dram_clk_off), 1);
    @(negedge clk); txn_new = 1; txn_empty = 0;
    tick(1);
    chk("R9 exit_req self refresh", int'(exit_req), 2);
    chk("R8 no clock stop during exit", int'(dram_clk_off), 0);
    @(negedge clk); txn_new = 0; pd_en = 0; sra_en = 0;
    finish_exit();

    // R10/R4/R6: software beats deep power-down on LPDDR3
    @(negedge clk); kind = 2; dpd_en = 1; sw = 1; txn_empty = 1;
    tick(1);
    chk("R10 software self refresh wins", int'(lp_state), 2);
    @(negedge clk); sw = 0;
    tick(1);
    chk("R4 software exit requested", int'(exit_req), 2);
    finish_exit();
    tick(1);
    chk("R6 deep power-down entered", int'(lp_state), 4);
    chk("R8 LPDDR3 deep power-down clock stop", int'(dram_clk_off), 1);
    @(negedge clk); sw = 1;
    tick(3);
    chk("R4 software ignored in deep power-down", int'(lp_state), 4);
    chk("R4 no exit from software bit", int'(exit_req), 0);
    @(negedge clk); sw = 0; dpd_en = 0;
    tick(1);
    chk("R6 exit on enable cleared", int'(exit_req), 8);
    @(negedge clk); exit_done = 1;
    tick(1);
    chk("R6 normal after exit", int'(lp_state), 0);
    chk("R6 reinit pulse", int'(reinit_req), 1);
    @(negedge clk); exit_done = 0;
    tick(1);
    chk("R6 reinit one cycle", int'(reinit_req), 0);

    // R7: maximum power saving only on DDR4
    @(negedge clk); kind = 0; mps_en = 1;
    tick(10);
    chk("R7 DDR3 ignores power saving", int'(lp_state), 0);
    @(negedge clk); kind = 1;
    tick(1);
    chk("R7 power saving entered", int'(lp_state), 5);
    chk("R8 DDR4 power saving clock stop", int'(dram_clk_off), 1);
    @(negedge clk); sw = 1;
    tick(2);
    chk("R4 software ignored in power saving", int'(lp_state), 5);
    @(negedge clk); sw = 0; mps_en = 0;
    tick(1);
    chk("R7 exit on enable cleared", int'(exit_req), 16);
    finish_exit();

    // R5: LPDDR4 intermediate self refresh with hold
    @(negedge clk); kind = 3; hold = 1; sw = 1;
    tick(1);
    chk("R5 self refresh entered", int'(lp_state), 2);
    chk("R11 enter pulse sr", int'(enter_req), 2);
    tick(4);
    chk("R5 hold keeps self refresh", int'(lp_state), 2);
    chk("R8 LPDDR4 self refresh clock runs", int'(dram_clk_off), 0);
    @(negedge clk); hold = 0;
    tick(1);
    chk("R5 self-refresh power-down", int'(lp_state), 3);
    chk("R8 LPDDR4 sr power-down clock stop", int'(dram_clk_off), 1);
    @(negedge clk); hold = 1; sw = 0;
    tick(1);
    chk("R5 back through self refresh", int'(lp_state), 2);
    chk("R11 enter pulse sr again", int'(enter_req), 2);
    tick(3);
    chk("R5 hold blocks exit", int'(exit_req), 0);
    chk("R5 hold keeps state", int'(lp_state), 2);
    @(negedge clk); hold = 0;
    tick(1);
    chk("R5 exit after hold released", int'(exit_req), 2);
    finish_exit();

    // R4: init blocks software entry; R8 enable off
    @(negedge clk); kind = 0; init_busy = 1; sw = 1; ck_en = 0;
    tick(5);
    chk("R4 ignored during init", int'(lp_state), 0);
    @(negedge clk); init_busy = 0;
    tick(1);
    chk("R4 entry after init", int'(lp_state), 2);
    chk("R8 clock stop disabled", int'(dram_clk_off), 0);
    @(negedge clk); sw = 0;
    tick(1);
    finish_exit();

    tick(5);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL R12 watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule